// File: doc/BRIEF.md
# Pipeline Data-Hazard Interlock

This block guards the decode stage of a five-stage, 16-bit in-order pipeline that settles read-after-write conflicts only by stalling. In every cycle it compares the two source-register fields of the instruction waiting in decode with the destination field and register-write flag of the three older instructions still in flight: the one in execute, the one in memory access and the one in write-back. If an older instruction is about to write a register that decode wants to read, the unit freezes the program counter and the fetch/decode register. It also replaces the decode output with an empty slot: opcode 0000 and every control line cleared.

The stall length depends on how close the producer is. A producer in execute (one instruction ahead) costs three cycles. A producer in memory access (two ahead) costs two. A producer in write-back (three ahead) costs one. When several stages match, the nearest one sets the length. The length is loaded into a down-counter. While that counter runs, the unit ignores its register-stage inputs and makes no new check.

The controller has two states. `ST_RUN` checks for hazards every cycle. `ST_FREEZE` holds while the counter is non-zero. The transitions are:

- T_ENTER (`ST_RUN` to `ST_FREEZE`): a match of length two or three is found.
- T_STAY (`ST_RUN` to `ST_RUN`): there is no match, or a one-cycle match that ends in the same cycle.
- T_COUNT (`ST_FREEZE` to `ST_FREEZE`): the counter is still above one.
- T_RELEASE (`ST_FREEZE` to `ST_RUN`): the counter reaches one.

In the cycle a match is found, the hold and bubble outputs are already asserted, combinationally from the comparison.

Top module: `hazard_interlock`

## Requirements
- R1: While the synchronous reset `rst` is high, `pc_hold`, `ifid_hold` and `bubble` are 0 whatever the other inputs are. After reset the controller is in `ST_RUN` with the counter at zero.
- R2: In `ST_RUN`, if `ex_wen`=1 and `ex_dst` equals a source field, the stall outputs are 1 in that cycle and in the next two (three cycles in total).
- R3: In `ST_RUN`, if `mem_wen`=1 and `mem_dst` equals a source field, and execute does not match, the stall outputs are 1 for two cycles.
- R4: In `ST_RUN`, if `wb_wen`=1 and `wb_dst` equals a source field, and neither nearer stage matches, the stall outputs are 1 for exactly one cycle.
- R5: A match on either `src_a` or `src_b` triggers the stall.
- R6: A stage whose write flag is 0 never causes a stall, even if its destination matches.
- R7: A destination of register 0 never causes a stall.
- R8: When several stages match at once, the nearest stage (execute before memory before write-back) sets the length.
- R9: In `ST_FREEZE` the register-stage inputs are ignored. The next hazard check happens in the cycle after the last stall cycle, and a match found then starts a new stall at once.
- R10: While `bubble`=1, `exe_op` is 4'b0000 and `exe_ctrl` is all zeros. Otherwise `exe_op` equals `dec_op` and `exe_ctrl` equals `dec_ctrl`.
- R11: `pc_hold`, `ifid_hold` and `bubble` are always asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_a | input | 3 | First source register of the instruction in decode |
| src_b | input | 3 | Second source register of the instruction in decode |
| ex_dst | input | 3 | Destination register of the instruction in execute |
| ex_wen | input | 1 | Register-write flag of the instruction in execute |
| mem_dst | input | 3 | Destination register of the instruction in memory access |
| mem_wen | input | 1 | Register-write flag of the instruction in memory access |
| wb_dst | input | 3 | Destination register of the instruction in write-back |
| wb_wen | input | 1 | Register-write flag of the instruction in write-back |
| dec_op | input | 4 | Opcode produced by decode |
| dec_ctrl | input | 8 | Control lines produced by decode |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the fetch/decode register |
| bubble | output | 1 | Replace the decode output with an empty slot |
| exe_op | output | 4 | Opcode forwarded toward execute |
| exe_ctrl | output | 8 | Control lines forwarded toward execute |

## Verification
The hardest case to reach is a fresh hazard that arrives while a stall is already running, or in the exact cycle after it ends. The counter is internal, so the bench can observe it only through the length of the hold pulse. The stimulus therefore keeps matching destinations on the stage inputs during the freeze cycles, which must be ignored. It then presents a new producer in the release cycle and checks that a new stall of the right length begins at once. Multi-stage matches and a reset in the middle of a stall are also driven, so that the counter is seen to reload and to clear.

// File: rtl/hil_pkg.sv
package hil_pkg;
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_FREEZE = 1'b1
    } hil_state_e;
endpackage

// File: rtl/hil_match.sv
module hil_match #(
    parameter int REG_W  = 3,
    parameter int STAGES = 3,
    localparam int CW    = $clog2(STAGES + 1)
) (
    input  logic [STAGES-1:0][REG_W-1:0] dst,
    input  logic [STAGES-1:0]            wen,
    input  logic [REG_W-1:0]             src_a,
    input  logic [REG_W-1:0]             src_b,
    output logic [CW-1:0]                need
);
    logic [STAGES-1:0] hit;

    // one comparator pair per older stage; index 0 is the nearest producer
    for (genvar k = 0; k < STAGES; k++) begin : g_cmp
        assign hit[k] = wen[k] && (dst[k] != '0) &&
                        ((dst[k] == src_a) || (dst[k] == src_b));
    end

    // farthest first so that the nearest match overrides
    always_comb begin
        need = '0;
        for (int k = STAGES - 1; k >= 0; k--) begin
            if (hit[k]) need = CW'(STAGES - k);
        end
    end
endmodule

// File: rtl/hil_fsm.sv
module hil_fsm
    import hil_pkg::*;
#(
    parameter int STAGES = 3,
    localparam int CW    = $clog2(STAGES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] need,
    output logic          stall
);
    hil_state_e    state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // next state, counter and outputs
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        stall     = 1'b0;
        unique case (state)
            ST_RUN: begin
                stall = (need != '0);
                if (need > CW'(1)) begin          // T_ENTER
                    nxt_state = ST_FREEZE;
                    nxt_cnt   = need - CW'(1);
                end
            end
            ST_FREEZE: begin
                stall = 1'b1;
                if (cnt <= CW'(1)) begin          // T_RELEASE
                    nxt_state = ST_RUN;
                    nxt_cnt   = '0;
                end else begin                    // T_COUNT
                    nxt_cnt = cnt - CW'(1);
                end
            end
            default: begin
                nxt_state = ST_RUN;
                nxt_cnt   = '0;
            end
        endcase
        if (rst) stall = 1'b0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (state == ST_RUN && cnt == '0));
    assert_freeze_count_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FREEZE) |-> (cnt != '0 && cnt < CW'(STAGES)));
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FREEZE && cnt == CW'(1)) |=> (state == ST_RUN));
endmodule

// File: rtl/hil_bubble.sv
module hil_bubble #(
    parameter int OP_W   = 4,
    parameter int CTRL_W = 8
) (
    input  logic              bubble,
    input  logic [OP_W-1:0]   dec_op,
    input  logic [CTRL_W-1:0] dec_ctrl,
    output logic [OP_W-1:0]   exe_op,
    output logic [CTRL_W-1:0] exe_ctrl
);
    localparam logic [OP_W-1:0] NOP_OP = '0;

    always_comb begin
        exe_op   = bubble ? NOP_OP : dec_op;
        exe_ctrl = bubble ? '0     : dec_ctrl;
    end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
    parameter int REG_W  = 3,
    parameter int OP_W   = 4,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [REG_W-1:0]  ex_dst,
    input  logic              ex_wen,
    input  logic [REG_W-1:0]  mem_dst,
    input  logic              mem_wen,
    input  logic [REG_W-1:0]  wb_dst,
    input  logic              wb_wen,
    input  logic [OP_W-1:0]   dec_op,
    input  logic [CTRL_W-1:0] dec_ctrl,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              bubble,
    output logic [OP_W-1:0]   exe_op,
    output logic [CTRL_W-1:0] exe_ctrl
);
    localparam int STAGES = 3;
    localparam int CW     = $clog2(STAGES + 1);

    logic [STAGES-1:0][REG_W-1:0] dst_v;
    logic [STAGES-1:0]            wen_v;
    logic [CW-1:0]                need;
    logic                         stall;

    assign dst_v = {wb_dst, mem_dst, ex_dst};
    assign wen_v = {wb_wen, mem_wen, ex_wen};

    hil_match #(.REG_W(REG_W), .STAGES(STAGES)) u_match (
        .dst(dst_v), .wen(wen_v), .src_a(src_a), .src_b(src_b), .need(need)
    );

    hil_fsm #(.STAGES(STAGES)) u_fsm (
        .clk(clk), .rst(rst), .need(need), .stall(stall)
    );

    assign pc_hold   = stall;
    assign ifid_hold = stall;
    assign bubble    = stall;

    hil_bubble #(.OP_W(OP_W), .CTRL_W(CTRL_W)) u_bubble (
        .bubble(stall), .dec_op(dec_op), .dec_ctrl(dec_ctrl),
        .exe_op(exe_op), .exe_ctrl(exe_ctrl)
    );

    assert_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
        (!ex_wen && !mem_wen && !wb_wen && !$past(pc_hold)) |-> !pc_hold);
    assert_ex_len_R2: assert property (@(posedge clk) disable iff (rst)
        (ex_wen && ex_dst != '0 && (ex_dst == src_a || ex_dst == src_b) && !$past(pc_hold))
        |-> pc_hold ##1 pc_hold ##1 pc_hold);
    assert_empty_slot_R10: assert property (@(posedge clk) disable iff (rst)
        bubble |-> (exe_op == '0 && exe_ctrl == '0));
endmodule

// File: tb/hazard_interlock_tb.sv
module hazard_interlock_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] src_a = '0, src_b = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic       ex_wen = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic [3:0] dec_op = '0;
    logic [7:0] dec_ctrl = '0;
    logic       pc_hold, ifid_hold, bubble;
    logic [3:0] exe_op;
    logic [7:0] exe_ctrl;

    typedef struct {
        logic       stall;
        logic [3:0] op;
        logic [7:0] ctrl;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    int   seq = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    hazard_interlock dut_i (
        .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .dec_op(dec_op), .dec_ctrl(dec_ctrl),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .bubble(bubble),
        .exe_op(exe_op), .exe_ctrl(exe_ctrl)
    );

    // driver: one vector per cycle, expected item pushed to the scoreboard
    task automatic v(input logic r, input logic [2:0] a, input logic [2:0] b,
                     input logic [2:0] ed, input logic ew,
                     input logic [2:0] md, input logic mw,
                     input logic [2:0] wd, input logic ww,
                     input logic exp_stall, input string tag);
        exp_t e;
        @(negedge clk);
        seq++;
        rst = r; src_a = a; src_b = b;
        ex_dst = ed; ex_wen = ew; mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
        dec_op   = 4'(seq % 15 + 1);
        dec_ctrl = 8'(seq * 37 + 11) | 8'h01;
        e.stall = exp_stall;
        e.op    = exp_stall ? 4'h0 : dec_op;     // R10 empty slot
        e.ctrl  = exp_stall ? 8'h00 : dec_ctrl;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        v(0, 3'd1, 3'd2, 3'd0, 0, 3'd0, 0, 3'd0, 0, 0, tag);
    endtask

    // monitor: pop and compare between edges
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                vectors++;
                if (pc_hold !== e.stall || ifid_hold !== e.stall || bubble !== e.stall ||
                    exe_op !== e.op || exe_ctrl !== e.ctrl) begin
                    miscompares++;
                    $display("FAIL %s: actual hold=%b/%b/%b op=%h ctrl=%h expected hold=%b op=%h ctrl=%h",
                             e.tag, pc_hold, ifid_hold, bubble, exe_op, exe_ctrl,
                             e.stall, e.op, e.ctrl);
                end
            end
        end
    end

    initial begin
        // R1: reset suppresses stall even with a matching producer
        v(1, 3'd3, 3'd4, 3'd3, 1, 3'd0, 0, 3'd0, 0, 0, "R1 reset quiet");
        v(1, 3'd3, 3'd4, 3'd3, 1, 3'd0, 0, 3'd0, 0, 0, "R1 reset quiet");
        v(0, 3'd1, 3'd2, 3'd3, 1, 3'd4, 1, 3'd5, 1, 0, "R5 baseline no match");
        // R2: execute producer, three cycles; R9 inputs ignored while frozen
        v(0, 3'd3, 3'd4, 3'd3, 1, 3'd0, 0, 3'd0, 0, 1, "R2 ex cycle1");
        v(0, 3'd3, 3'd4, 3'd3, 1, 3'd0, 0, 3'd0, 0, 1, "R9 ex cycle2 match ignored");
        v(0, 3'd1, 3'd2, 3'd0, 0, 3'd0, 0, 3'd0, 0, 1, "R9 ex cycle3 no-match ignored");
        idle("R2 release after three");
        // R3: memory producer on src_b, two cycles
        v(0, 3'd1, 3'd5, 3'd0, 0, 3'd5, 1, 3'd0, 0, 1, "R3 mem cycle1");
        v(0, 3'd1, 3'd5, 3'd0, 0, 3'd5, 1, 3'd0, 0, 1, "R3 mem cycle2");
        idle("R3 release after two");
        // R4: write-back producer, one cycle, then a fresh check each cycle
        v(0, 3'd6, 3'd2, 3'd0, 0, 3'd0, 0, 3'd6, 1, 1, "R4 wb single");
        v(0, 3'd6, 3'd2, 3'd0, 0, 3'd0, 0, 3'd6, 1, 1, "R4 wb again");
        idle("R4 release after one");
        // R6: write flags low
        v(0, 3'd3, 3'd4, 3'd3, 0, 3'd4, 0, 3'd3, 0, 0, "R6 no write");
        // R7: register zero
        v(0, 3'd0, 3'd0, 3'd0, 1, 3'd0, 1, 3'd0, 1, 0, "R7 reg zero");
        // R5: match through src_b on execute
        v(0, 3'd1, 3'd7, 3'd7, 1, 3'd0, 0, 3'd0, 0, 1, "R5 srcb cycle1");
        idle("R5 srcb cycle2");
        q[q.size()-1].stall = 1; q[q.size()-1].op = 4'h0; q[q.size()-1].ctrl = 8'h00;
        idle("R5 srcb cycle3");
        q[q.size()-1].stall = 1; q[q.size()-1].op = 4'h0; q[q.size()-1].ctrl = 8'h00;
        idle("R5 release");
        // R8: nearest wins (ex+mem+wb -> 3, mem+wb -> 2)
        v(0, 3'd2, 3'd3, 3'd2, 1, 3'd3, 1, 3'd2, 1, 1, "R8 all match c1");
        v(0, 3'd1, 3'd2, 3'd0, 0, 3'd0, 0, 3'd0, 0, 1, "R8 all match c2");
        v(0, 3'd1, 3'd2, 3'd0, 0, 3'd0, 0, 3'd0, 0, 1, "R8 all match c3");
        idle("R8 release three");
        v(0, 3'd4, 3'd5, 3'd0, 0, 3'd5, 1, 3'd4, 1, 1, "R8 mem+wb c1");
        v(0, 3'd1, 3'd2, 3'd0, 0, 3'd0, 0, 3'd0, 0, 1, "R8 mem+wb c2");
        idle("R8 release two");
        // R9: new hazard in the release cycle starts at once
        v(0, 3'd3, 3'd1, 3'd3, 1, 3'd0, 0, 3'd0, 0, 1, "R9 first c1");
        v(0, 3'd3, 3'd1, 3'd0, 0, 3'd3, 1, 3'd0, 0, 1, "R9 first c2");
        v(0, 3'd3, 3'd1, 3'd0, 0, 3'd0, 0, 3'd3, 1, 1, "R9 first c3");
        v(0, 3'd2, 3'd6, 3'd0, 0, 3'd6, 1, 3'd0, 0, 1, "R9 new check c1");
        v(0, 3'd2, 3'd6, 3'd6, 1, 3'd0, 0, 3'd0, 0, 1, "R9 new c2 ignored");
        idle("R9 new release");
        // R1 and R11: reset in the middle of a stall clears the counter
        v(0, 3'd3, 3'd4, 3'd3, 1, 3'd0, 0, 3'd0, 0, 1, "R11 joint assert");
        v(1, 3'd1, 3'd2, 3'd0, 0, 3'd0, 0, 3'd0, 0, 0, "R1 reset mid stall");
        idle("R1 counter cleared");
        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            miscompares++;
            $display("FAIL R11 scoreboard: actual %0d pending expected 0", q.size());
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
        $finish;
    end
endmodule